// File: doc/BRIEF.md
# External Reset Pin Manager

This block sits on the slow always-on clock and looks after a bidirectional, active-low system reset pin. It passes the pin through a two-flop synchronizer and watches the result for a falling edge. When it sees one, it either hands a one-cycle user-reset request to the reset sequencer or raises an interrupt. The choice depends on two configuration inputs. Every detected assertion also sets a sticky event flag. The flag stays set until software reads the status. The synchronized pin level is always visible as a status bit.

The sequencer can also ask the block to pull the pin low itself. A rising edge on the request starts a timed pulse on the open-drain drive enable. The pulse lasts 2^(N+1) slow-clock cycles, where N is a 4-bit length input. The block drives the pin low for the whole pulse. That self-inflicted low is never mistaken for a user assertion. The length and enable inputs come from configuration storage that lives outside the core reset domain. The block reads them live and keeps no copy, so a pulse that starts right after a core reset already has the right length.

Top module: `ext_rst_pin_mgr`

## Requirements
- R1: `pin_lvl_o` equals `pin_i` delayed by two slow-clock cycles through a two-flop synchronizer.
- R2: A high-to-low transition of the synchronized pin level, with `usr_rst_en_i`=1 and `usr_irq_en_i`=0, produces exactly one cycle of `usr_rst_o`=1.
- R3: With `usr_rst_en_i`=0, a pin assertion never raises `usr_rst_o`.
- R4: With `usr_irq_en_i`=1, a pin assertion never raises `usr_rst_o`. `irq_o` is high whenever `evt_flag_o`=1 and `usr_irq_en_i`=1.
- R5: Every detected pin assertion sets `evt_flag_o`, whatever the enables are. The flag then stays at 1 until a status read.
- R6: `stat_rd_i`=1 at a clock edge clears `evt_flag_o`. If a new pin assertion is detected at the same edge, the flag stays at 1.
- R7: A rising edge of `ext_req_i` makes `pin_drive_o` (1 = pull pin low) high for exactly 2^(N+1) consecutive cycles, with N = `pulse_len_i`. N=0 gives 2 cycles and N=15 gives 65536 cycles.
- R8: Holding `ext_req_i` high during or after a pulse neither lengthens nor restarts it. A new pulse needs a new rising edge of `ext_req_i`.
- R9: A pin low caused by the block's own drive pulse sets neither `evt_flag_o` nor `usr_rst_o`.
- R10: While `rst_ni`=0 and after its release, `pin_drive_o`, `usr_rst_o`, `irq_o` and `evt_flag_o` are 0 and `pin_lvl_o` is 1. The pulse length is taken live from `pulse_len_i` and is not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Slow always-on clock |
| rst_ni | input | 1 | Asynchronous active-low core reset |
| usr_rst_en_i | input | 1 | Allow pin assertions to request a user reset |
| usr_irq_en_i | input | 1 | Route pin assertions to the interrupt instead of a reset |
| pulse_len_i | input | 4 | Drive pulse length exponent N (2^(N+1) cycles) |
| pin_i | input | 1 | Sampled level of the reset pin |
| ext_req_i | input | 1 | Sequencer request to pull the pin low |
| stat_rd_i | input | 1 | Status read strobe; clears the sticky flag |
| pin_drive_o | output | 1 | Open-drain enable; 1 pulls the pin low |
| usr_rst_o | output | 1 | One-cycle user-reset request to the sequencer |
| irq_o | output | 1 | Interrupt request |
| pin_lvl_o | output | 1 | Synchronized pin level |
| evt_flag_o | output | 1 | Sticky pin-assertion flag |

## Verification
External presses are applied under all four combinations of the two enables. These cases tell reset routing apart from interrupt routing, and both apart from the case where the press is only logged. Drive pulses are requested with lengths 0, 1, 3, 6 and 15, with the request held high past the end of the pulse. These cases separate an off-by-one or wrong exponent from a pulse that retriggers. The drive pulses run with the pin looped back through an open-drain model, so the same runs also show whether self-driven lows leak into the event path. A status read is lined up with the edge where a new press is detected, to show that the set wins over the clear.

// File: rtl/ext_rst_pkg.sv
package ext_rst_pkg;
  localparam int unsigned LEN_W       = 4;
  localparam int unsigned CNT_W       = (1 << LEN_W) + 1;
  localparam int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '1;  // idle pin is high
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/drive_pulse_timer.sv
module drive_pulse_timer #(
  parameter int unsigned LEN_W = 4,
  parameter int unsigned CNT_W = 17
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             drive_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic             req_q, busy_q;
  logic [CNT_W-1:0] cnt_q;
  logic [LEN_W:0]   shamt;
  logic [CNT_W-1:0] load_val;
  logic             start;

  assign shamt    = {1'b0, len_i} + 1'b1;
  assign load_val = (ONE << shamt) - ONE;
  assign start    = req_i & ~req_q & ~busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= 1'b0;
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      req_q <= req_i;
      if (start) begin
        busy_q <= 1'b1;
        cnt_q  <= load_val;
      end else if (busy_q) begin
        if (cnt_q == '0) busy_q <= 1'b0;
        else             cnt_q  <= cnt_q - ONE;
      end
    end
  end

  assign drive_o = busy_q;
endmodule

// File: rtl/usr_evt_unit.sv
module usr_evt_unit #(
  parameter int unsigned MASK_LEN = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  input  logic drive_i,
  input  logic rst_en_i,
  input  logic irq_en_i,
  input  logic rd_i,
  output logic usr_rst_o,
  output logic flag_o
);
  logic                lvl_q;
  logic [MASK_LEN-1:0] drv_hist_q;
  logic                self_low, evt;
  logic                usr_rst_q, flag_q;

  // own drive reaches the synced level MASK_LEN cycles late
  assign self_low = drive_i | (|drv_hist_q);
  assign evt      = lvl_q & ~lvl_i & ~self_low;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q      <= 1'b1;
      drv_hist_q <= '0;
      usr_rst_q  <= 1'b0;
      flag_q     <= 1'b0;
    end else begin
      lvl_q      <= lvl_i;
      drv_hist_q <= {drv_hist_q[MASK_LEN-2:0], drive_i};
      usr_rst_q  <= evt & rst_en_i & ~irq_en_i;
      if (evt)       flag_q <= 1'b1;
      else if (rd_i) flag_q <= 1'b0;
    end
  end

  assign usr_rst_o = usr_rst_q;
  assign flag_o    = flag_q;
endmodule

// File: rtl/ext_rst_pin_mgr.sv
module ext_rst_pin_mgr
  import ext_rst_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             usr_rst_en_i,
  input  logic             usr_irq_en_i,
  input  logic [LEN_W-1:0] pulse_len_i,
  input  logic             pin_i,
  input  logic             ext_req_i,
  input  logic             stat_rd_i,
  output logic             pin_drive_o,
  output logic             usr_rst_o,
  output logic             irq_o,
  output logic             pin_lvl_o,
  output logic             evt_flag_o
);
  logic lvl_s, drive_s, flag_s;

  pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pin_i), .q_o(lvl_s)
  );

  drive_pulse_timer #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(ext_req_i),
    .len_i(pulse_len_i), .drive_o(drive_s)
  );

  usr_evt_unit #(.MASK_LEN(SYNC_STAGES)) u_evt (
    .clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(lvl_s), .drive_i(drive_s),
    .rst_en_i(usr_rst_en_i), .irq_en_i(usr_irq_en_i), .rd_i(stat_rd_i),
    .usr_rst_o(usr_rst_o), .flag_o(flag_s)
  );

  assign pin_drive_o = drive_s;
  assign pin_lvl_o   = lvl_s;
  assign evt_flag_o  = flag_s;
  assign irq_o       = flag_s & usr_irq_en_i;
endmodule

// File: rtl/ext_rst_pin_mgr_chk.sv
module ext_rst_pin_mgr_chk
  import ext_rst_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             usr_rst_en_i,
  input logic             usr_irq_en_i,
  input logic [LEN_W-1:0] pulse_len_i,
  input logic             pin_i,
  input logic             ext_req_i,
  input logic             stat_rd_i,
  input logic             pin_drive_o,
  input logic             usr_rst_o,
  input logic             irq_o,
  input logic             pin_lvl_o,
  input logic             evt_flag_o
);
  logic [CNT_W:0]   run_q;
  logic [LEN_W-1:0] len_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= '0;
      len_q <= '0;
    end else begin
      run_q <= pin_drive_o ? run_q + 1'b1 : '0;
      if (!pin_drive_o) len_q <= pulse_len_i;
    end
  end

  AST_PULSE_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pin_drive_o) |-> run_q == ((CNT_W+1)'(2) << len_q));  // R7
  AST_DRIVE_NEEDS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pin_drive_o) |-> $past(ext_req_i));  // R8
  AST_USR_RST_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    usr_rst_o |=> !usr_rst_o);  // R2
  AST_USR_RST_ROUTING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    usr_rst_o |-> $past(usr_rst_en_i && !usr_irq_en_i));  // R3
  AST_FLAG_CLEAR_BY_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(evt_flag_o) |-> $past(stat_rd_i));  // R6
  AST_FLAG_FROM_LOW_PIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(evt_flag_o) |-> !$past(pin_lvl_o));  // R5
  AST_IRQ_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> evt_flag_o && usr_irq_en_i);  // R4
endmodule

bind ext_rst_pin_mgr ext_rst_pin_mgr_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .usr_rst_en_i(usr_rst_en_i),
  .usr_irq_en_i(usr_irq_en_i), .pulse_len_i(pulse_len_i), .pin_i(pin_i),
  .ext_req_i(ext_req_i), .stat_rd_i(stat_rd_i), .pin_drive_o(pin_drive_o),
  .usr_rst_o(usr_rst_o), .irq_o(irq_o), .pin_lvl_o(pin_lvl_o),
  .evt_flag_o(evt_flag_o)
);

// File: tb/sim_ext_rst_pin_mgr.sv
module sim_ext_rst_pin_mgr;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rst_en = 1'b0, irq_en = 1'b0, ext_req = 1'b0, stat_rd = 1'b0;
  logic [3:0] plen = 4'd0;
  logic       ext_low = 1'b0;
  logic       pin;
  logic       drive, urst, irq, lvl, flag;
  int         n_chk = 0, n_bad = 0, rst_pulses = 0;

  always #2 clk = ~clk;  // 250 MHz

  assign pin = ~(ext_low | drive);  // open-drain loopback

  ext_rst_pin_mgr u0 (
    .clk_i(clk), .rst_ni(rst_n), .usr_rst_en_i(rst_en), .usr_irq_en_i(irq_en),
    .pulse_len_i(plen), .pin_i(pin), .ext_req_i(ext_req), .stat_rd_i(stat_rd),
    .pin_drive_o(drive), .usr_rst_o(urst), .irq_o(irq), .pin_lvl_o(lvl),
    .evt_flag_o(flag)
  );

  always @(negedge clk) if (urst) rst_pulses++;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // {kind(1: drive, 0: press), len(4), rst_en, irq_en, exp(17)}
  // drive: exp = pulse cycles; press: exp[0] = reset pulses, exp[1] = irq level
  localparam int NV = 9;
  localparam logic [23:0] VEC [NV] = '{
    {1'b1, 4'd0, 1'b1, 1'b0, 17'd2},
    {1'b1, 4'd1, 1'b1, 1'b0, 17'd4},
    {1'b1, 4'd3, 1'b0, 1'b1, 17'd16},
    {1'b1, 4'd6, 1'b1, 1'b0, 17'd128},
    {1'b0, 4'd0, 1'b1, 1'b0, 17'd1},
    {1'b0, 4'd0, 1'b0, 1'b0, 17'd0},
    {1'b0, 4'd0, 1'b1, 1'b1, 17'd2},
    {1'b0, 4'd0, 1'b0, 1'b1, 17'd2},
    {1'b1, 4'd15, 1'b1, 1'b0, 17'd65536}
  };

  task automatic do_drive(input int exp);
    int cnt = 0;
    rst_pulses = 0;
    ext_req = 1'b1;
    tick(1);
    while (drive && cnt < 70000) begin cnt++; tick(1); end
    chk("R7 pulse length", cnt, exp);
    tick(6);
    chk("R8 no retrigger while held", int'(drive), 0);
    ext_req = 1'b0;
    tick(2);
    chk("R9 no flag from own drive", int'(flag), 0);
    chk("R9 no user reset from own drive", rst_pulses, 0);
  endtask

  task automatic do_press(input logic [16:0] exp);
    rst_pulses = 0;
    ext_low = 1'b1;
    tick(5);
    chk("R5 flag set by press", int'(flag), 1);
    chk("R2/R3/R4 reset pulses", rst_pulses, int'(exp[0]));
    chk("R4 irq level", int'(irq), int'(exp[1]));
    ext_low = 1'b0;
    tick(4);
    chk("R5 flag sticky after release", int'(flag), 1);
    stat_rd = 1'b1; tick(1); stat_rd = 1'b0;
    chk("R6 read clears flag", int'(flag), 0);
    chk("R4 irq drops with flag", int'(irq), 0);
  endtask

  initial begin
    tick(3);
    chk("R10 reset drive", int'(drive), 0);
    chk("R10 reset flag", int'(flag), 0);
    chk("R10 reset irq", int'(irq), 0);
    chk("R10 reset level", int'(lvl), 1);
    rst_n = 1'b1;
    tick(3);
    chk("R10 after release usr_rst", int'(urst), 0);

    for (int v = 0; v < NV; v++) begin
      plen   = VEC[v][22:19];
      rst_en = VEC[v][18];
      irq_en = VEC[v][17];
      if (VEC[v][23]) do_drive(int'(VEC[v][16:0]));
      else            do_press(VEC[v][16:0]);
      tick(3);
    end

    // R1: two-cycle latency of the level
    ext_low = 1'b1;
    tick(1); chk("R1 level after 1 cycle", int'(lvl), 1);
    tick(1); chk("R1 level after 2 cycles", int'(lvl), 0);
    ext_low = 1'b0;
    tick(1); chk("R1 level holds 1 cycle", int'(lvl), 0);
    tick(1); chk("R1 level back high", int'(lvl), 1);
    tick(3);
    chk("R6 flag set before overlap test", int'(flag), 1);

    // R6: read lands on the edge that detects a new press
    ext_low = 1'b1;
    tick(2);
    stat_rd = 1'b1;
    tick(1);
    stat_rd = 1'b0;
    chk("R6 set wins over same-edge read", int'(flag), 1);
    ext_low = 1'b0;
    tick(4);
    stat_rd = 1'b1; tick(1); stat_rd = 1'b0;
    chk("R6 later read clears", int'(flag), 0);

    // R8: a fresh edge after the pulse starts a new one
    plen = 4'd0;
    ext_req = 1'b1; tick(8); ext_req = 1'b0; tick(2);
    ext_req = 1'b1; tick(1);
    chk("R8 new edge restarts", int'(drive), 1);
    ext_req = 1'b0; tick(4);

    // R10: core reset mid-pulse, then a pulse right after release
    plen = 4'd2;
    ext_req = 1'b1; tick(3);
    rst_n = 1'b0; ext_req = 1'b0; tick(1);
    chk("R10 reset stops drive", int'(drive), 0);
    tick(2); rst_n = 1'b1; tick(1);
    begin
      int cnt = 0;
      ext_req = 1'b1; tick(1);
      while (drive && cnt < 100) begin cnt++; tick(1); end
      chk("R10 live length after reset", cnt, 8);
      ext_req = 1'b0;
    end
    tick(4);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule